// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter

This block turns a 7-bit character from a host into one frame on a single serial line. It adds a low start bit, then the data bits starting with bit 0, then a parity bit, then a high stop bit. The host sets the parity bit's sense with a single control pin. Two parameters, the system clock frequency and the baud rate, fix the bit period as a whole number of clock cycles. With the defaults (125 MHz and 300 baud) one bit lasts about 416,666 cycles.

The host talks to the block over a four-phase level handshake, not a pulse. The host raises `req` and holds it. The block answers with `busy`, sends the frame, and lowers `busy` once the stop bit is done. It will not start another character until the host has dropped `req`. So `req` plays the part of a valid and `busy` the part of back-pressure. While `busy` is high, or while the block waits for `req` to drop, no new character is taken. The block samples the character and the parity select only when it loads the frame. After `busy` goes high the host may change them freely.

Inside, a restartable tick divider paces the bits, a modulo-10 slot counter tracks the frame position, and a 9-bit shift register holds the frame. A five-state controller sequences them.

Top module: `serial_char_tx`

## Requirements
- R1: After reset `ser_out` is 1 (mark) and `busy` is 0.
- R2: A frame puts on `ser_out`, in this order: one bit of 0, then `char_data[0]` through `char_data[6]`, then the parity bit, then one bit of 1. Each bit lasts exactly CLK_HZ/BAUD clock cycles.
- R3: With `odd_parity` = 0 the ones in data plus parity are an even count. With `odd_parity` = 1 they are an odd count.
- R4: If `req` is high while the block is idle, `busy` is 1 after the next rising edge. The start bit appears on `ser_out` one edge after that. `busy` comes straight from a flip-flop.
- R5: `busy` stays 1 from the start bit through the whole stop bit. It falls on the edge that ends the stop bit, 10 bit periods after the start bit began.
- R6: After `busy` falls, while `req` is still high, `ser_out` stays 1 and `busy` stays 0. A new frame can start only after `req` has been seen low.
- R7: `char_data` and `odd_parity` are captured when the frame loads. Changes made while `busy` is high do not alter the frame in flight.
- R8: The bit tick is high for one cycle at a time and never on two consecutive cycles.
- R9: The slot counter steps by one per shift. It raises its terminal flag on the shift taken while it holds 9, and then wraps to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host request, held high until `busy` has fallen |
| odd_parity | input | 1 | 0 = even parity, 1 = odd parity |
| char_data | input | DATA_W (7) | Character to send |
| ser_out | output | 1 | Serial line, idles at 1 |
| busy | output | 1 | Registered: high while a frame is in progress |

## Verification
The assertions check these on every cycle:
- the tick never fires twice in a row, and the slot counter steps and wraps as required;
- ones are fed into the frame register on each shift;
- the line drops to the start level right after a load;
- the line stays quiet while waiting for `req` to drop.

Only the bench scenarios can show the rest:
- that whole frames carry the right bits for the right number of cycles;
- that the parity sense follows `odd_parity`;
- that `busy` falls on the exact cycle the stop bit ends;
- that changing the inputs in mid-frame leaves the serial output untouched.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COUNT,
    ST_SHIFT,
    ST_WAIT
  } tx_state_e;
endpackage

// File: rtl/uftx_baud_tick.sv
module uftx_baud_tick #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(DIV - 1));

  // Restart value 1 makes the first bit after a restart last DIV cycles,
  // counting the shift cycle that follows the tick.
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= CW'(1);
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  p_tick_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/uftx_bit_count.sv
module uftx_bit_count #(
  parameter int unsigned SLOTS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic term
);
  localparam int unsigned CW = $clog2(SLOTS);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  logic [CW-1:0] cnt_q;

  assign term = inc && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (inc)      cnt_q <= term ? '0 : cnt_q + 1'b1;
  end

  p_wrap_after_term_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !clr) |=> (cnt_q == '0));

  p_step_by_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/uftx_frame_reg.sv
module uftx_frame_reg #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] pload,
  output logic         sout
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '1;
    else if (load)  q <= pload;
    else if (shift) q <= {1'b1, q[W-1:1]};
  end

  assign sout = q[0];

  p_fill_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> q[W-1]);
endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx #(
  parameter int unsigned CLK_HZ = 125_000_000,
  parameter int unsigned BAUD   = 300,
  parameter int unsigned DATA_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              odd_parity,
  input  logic [DATA_W-1:0] char_data,
  output logic              ser_out,
  output logic              busy
);
  import uftx_pkg::*;

  localparam int unsigned DIV     = CLK_HZ / BAUD;
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned SLOTS   = DATA_W + 3;

  tx_state_e st_q, st_d;
  logic tick, term, par_bit;
  logic do_load, do_shift;

  assign par_bit  = (^char_data) ^ odd_parity;
  assign do_load  = (st_q == ST_LOAD);
  assign do_shift = (st_q == ST_SHIFT);

  uftx_baud_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(do_load), .tick(tick)
  );

  uftx_bit_count #(.SLOTS(SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n), .clr(do_load), .inc(do_shift), .term(term)
  );

  uftx_frame_reg #(.W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(do_load), .shift(do_shift),
    .pload({par_bit, char_data, 1'b0}), .sout(ser_out)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req)  st_d = ST_LOAD;
      ST_LOAD:            st_d = ST_COUNT;
      ST_COUNT: if (tick) st_d = ST_SHIFT;
      ST_SHIFT:           st_d = term ? ST_WAIT : ST_COUNT;
      ST_WAIT:  if (!req) st_d = ST_IDLE;
      default:            st_d = ST_IDLE;
    endcase
  end

  // busy is registered from the next state so it never glitches
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      busy <= 1'b0;
    end else begin
      st_q <= st_d;
      busy <= (st_d == ST_LOAD) || (st_d == ST_COUNT) || (st_d == ST_SHIFT);
    end
  end

  p_start_after_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD) |=> !ser_out);

  p_busy_on_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req) |=> busy);

  p_quiet_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> (ser_out && !busy));

  p_hold_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && req) |=> (st_q == ST_WAIT));
endmodule

// File: tb/test_serial_char_tx.sv
module test_serial_char_tx;
  localparam int unsigned CLK_HZ = 1000;
  localparam int unsigned BAUD   = 125;
  localparam int DIV = CLK_HZ / BAUD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic odd_parity = 1'b0;
  logic [6:0] char_data = '0;
  logic ser_out, busy;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_char_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(7)) i_serial_char_tx (
    .clk(clk), .rst_n(rst_n), .req(req), .odd_parity(odd_parity),
    .char_data(char_data), .ser_out(ser_out), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ser_out in reset", 32'(ser_out), 1);
    check("R1 busy in reset", 32'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 ser_out idle", 32'(ser_out), 1);
    check("R1 busy idle", 32'(busy), 0);
  endtask

  // sends one character and checks it cycle by cycle
  task automatic t_frame(input logic [6:0] d, input logic odd, input bit mutate);
    logic [9:0] exp_bits;
    logic exp_par;
    logic [9:0] mid;
    bit line_ok = 1;
    bit busy_ok = 1;
    exp_par = (^d) ^ odd;
    exp_bits = {1'b1, exp_par, d, 1'b0};
    @(negedge clk);
    char_data = d;
    odd_parity = odd;
    req = 1'b1;
    @(negedge clk);
    check("R4 busy one edge after req", 32'(busy), 1);
    check("R4 line still idle in load cycle", 32'(ser_out), 1);
    for (int idx = 0; idx < 10 * DIV; idx++) begin
      @(negedge clk);
      if (mutate && idx == 3) begin
        char_data = ~d;
        odd_parity = ~odd;
      end
      if (ser_out !== exp_bits[idx / DIV]) begin
        line_ok = 0;
        $display("FAIL R2 bit %0d cycle %0d: actual %0b expected %0b", idx / DIV, idx, ser_out, exp_bits[idx / DIV]);
      end
      if (busy !== 1'b1) busy_ok = 0;
      if (idx % DIV == DIV / 2) mid[idx / DIV] = ser_out;
    end
    checks++; if (!line_ok) fails++;
    check(mutate ? "R7 frame unaffected by input change" : "R2 mid-bit frame", 32'(mid), 32'(exp_bits));
    check("R3 ones count parity", 32'($countones(mid[8:1]) % 2), 32'(odd));
    check("R5 busy held through frame", 32'(busy_ok), 1);
    @(negedge clk);
    check("R5 busy falls after stop bit", 32'(busy), 0);
    for (int k = 0; k < 3 * DIV; k++) begin
      @(negedge clk);
      if (ser_out !== 1'b1 || busy !== 1'b0) begin
        fails++;
        $display("FAIL R6 held req: actual line %0b busy %0b expected 1 0", ser_out, busy);
      end
    end
    checks++;
    req = 1'b0;
    @(negedge clk);
    check("R6 idle after req drop", 32'(busy), 0);
  endtask

  initial begin
    t_reset();
    t_frame(7'h57, 1'b0, 0);
    t_frame(7'h57, 1'b1, 0);
    t_frame(7'h00, 1'b0, 0);
    t_frame(7'h00, 1'b1, 0);
    t_frame(7'h7F, 1'b1, 0);
    t_frame(7'h2A, 1'b0, 1);
    t_frame(7'h41, 1'b1, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule